// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between a parallel host write bus and the internal engine of a byte-wide non-volatile array. It samples the chip-enable, write-enable and output-enable strobes on the system clock and turns each completed bus write into an address/data event. It then follows the multi-write unlock sequences that guard every state-changing command. When a sequence completes, it raises a request for one of three internal operations: byte program, whole-array erase, or boot-region lockout. The same sequences switch an identification mode on and off. While that mode is active, the read path returns identification bytes in place of array data.

All bus pins are taken as synchronous to `clk`. A write is the interval during which both `bus_ce_n` and `bus_we_n` are low. The operation request is a valid/ready output. `op_valid` rises one clock after the final write completes. Once raised, `op_valid` and its fields hold until the cycle in which `op_ready` is seen high, and the request drops after that edge. Back-pressure does not stall the bus. While a request is still waiting, or while `engine_busy` is high, completed writes are dropped and leave the decoder untouched. The unlock address pair and the two identification codes are parameters.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset the decoder is idle, `op_valid` is 0, `id_mode` is 0, and `rd_data` follows `array_rdata`.
- R2: A write captures the address of the first clock in which `bus_ce_n` and `bus_we_n` are both low. It captures the data of the last such clock. A write during which `bus_oe_n` was low at any sampled clock is discarded, and it neither advances nor resets the sequence.
- R3: The writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0xA0, then any address A with data D, give a request with `op_kind`=1 (program), `op_addr`=A and `op_data`=D.
- R4: The writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0x80, 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0x10 give a request with `op_kind`=2 (erase), `op_addr`=0x05555 and `op_data`=0x10.
- R5: The same six-write form ending in 0x05555←0x40 gives a request with `op_kind`=3 (lockout), `op_addr`=0x05555 and `op_data`=0x40.
- R6: The writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0x90 set `id_mode` to 1 and issue no request.
- R7: Data 0xF0 written to any address clears `id_mode` and returns the decoder to idle. This holds in every step except the program-data step, and so covers both the single-write exit and the three-write exit ending 0x05555←0xF0.
- R8: With `id_mode` 1, `rd_data` is 0x1F at read address 0, 0x17 at address 1, and {7'b0, `lock_state`} at address 2. It is 0x00 at any other address. With `id_mode` 0, `rd_data` equals `array_rdata`.
- R9: A write that is not the expected next step returns the decoder to idle without a request, and that write does not itself start a new sequence.
- R10: A write that completes while `engine_busy` is 1, or while `op_valid` is 1, is dropped. It changes neither the sequence step nor `id_mode`.
- R11: `op_valid`, `op_kind`, `op_addr` and `op_data` hold while `op_ready` is 0. `op_valid` is 0 in the clock after a cycle with `op_valid` and `op_ready` both 1.
- R12: In the program-data step, data 0xF0 is programmed as ordinary data and `id_mode` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low; low inhibits writes |
| bus_addr | input | 17 | Host address |
| bus_wdata | input | 8 | Host write data |
| engine_busy | input | 1 | Internal engine is executing an operation |
| lock_state | input | 1 | Current boot-region lockout status |
| op_valid | output | 1 | Operation request valid |
| op_ready | input | 1 | Engine accepts the request |
| op_kind | output | 2 | 1 program, 2 erase, 3 lockout |
| op_addr | output | 17 | Target address of the request |
| op_data | output | 8 | Data byte of the request |
| id_mode | output | 1 | Identification mode active |
| rd_addr | input | 17 | Read address |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data after identification mux |

## Verification
The bench moves the address after the strobe has fallen and changes the data after write-enable has risen. A decoder that latched at the wrong strobe edge would report the wrong target or the wrong byte. It sends near-miss sequences, such as the right data at the wrong unlock address or a wrong byte in the final step of the double-unlock commands. A decoder that failed to reset would then accept the next stray write as program data. It writes during busy and during a waiting request, and checks afterwards that the sequence resumes exactly where it stood. A design that let those writes through would launch a second operation or corrupt the pending one. It also programs the byte 0xF0, which a careless exit decoder would treat as an identification exit.

// File: rtl/ucd_pkg.sv
`timescale 1ns/1ps
package ucd_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_PROGRAM = 2'd1,
    OP_ERASE   = 2'd2,
    OP_LOCKOUT = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PDATA,
    S_SETUP,
    S_SKEY1,
    S_SKEY2
  } seq_state_e;

  localparam logic [DATA_W-1:0] KEY_FIRST    = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND   = 8'h55;
  localparam logic [DATA_W-1:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_SETUP    = 8'h80;
  localparam logic [DATA_W-1:0] CMD_ERASE    = 8'h10;
  localparam logic [DATA_W-1:0] CMD_LOCKOUT  = 8'h40;
  localparam logic [DATA_W-1:0] CMD_ID_ENTER = 8'h90;
  localparam logic [DATA_W-1:0] CMD_ID_EXIT  = 8'hF0;
endpackage

// File: rtl/ucd_bus_capture.sv
`timescale 1ns/1ps
module ucd_bus_capture #(
  parameter int ADDR_W = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       we_n,
  input  logic                       oe_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ucd_pkg::DATA_W-1:0] wdata,
  output logic                       ev_valid,
  output logic [ADDR_W-1:0]          ev_addr,
  output logic [ucd_pkg::DATA_W-1:0] ev_data
);
  logic active;
  logic act_q;
  logic inhib_q;
  logic [ADDR_W-1:0]          addr_q;
  logic [ucd_pkg::DATA_W-1:0] data_q;

  // a write lasts while both strobes are low: start = later falling edge,
  // end = earlier rising edge
  assign active = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      inhib_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      act_q <= active;
      if (active && !act_q) begin
        addr_q  <= addr;
        inhib_q <= !oe_n;
      end else if (active && !oe_n) begin
        inhib_q <= 1'b1;
      end
      if (active) data_q <= wdata;
    end
  end

  assign ev_valid = act_q && !active && !inhib_q;
  assign ev_addr  = addr_q;
  assign ev_data  = data_q;
endmodule

// File: rtl/ucd_seq_fsm.sv
`timescale 1ns/1ps
module ucd_seq_fsm #(
  parameter int          ADDR_W        = 17,
  parameter logic [16:0] UNLOCK_ADDR_A = 17'h05555,
  parameter logic [16:0] UNLOCK_ADDR_B = 17'h02AAA
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_valid,
  input  logic [ADDR_W-1:0]          ev_addr,
  input  logic [ucd_pkg::DATA_W-1:0] ev_data,
  input  logic                       engine_busy,
  output logic                       op_valid,
  input  logic                       op_ready,
  output ucd_pkg::op_kind_e          op_kind,
  output logic [ADDR_W-1:0]          op_addr,
  output logic [ucd_pkg::DATA_W-1:0] op_data,
  output logic                       id_mode
);
  import ucd_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);

  seq_state_e st_q, st_n;
  logic       id_q, id_n;
  logic       accept;
  logic       launch;
  op_kind_e   kind_n;
  logic       at_a, key_a, key_b;

  assign accept = ev_valid && !engine_busy && !op_valid;
  assign at_a   = (ev_addr == ADDR_A);
  assign key_a  = at_a && (ev_data == KEY_FIRST);
  assign key_b  = (ev_addr == ADDR_B) && (ev_data == KEY_SECOND);

  always_comb begin
    st_n   = st_q;
    id_n   = id_q;
    launch = 1'b0;
    kind_n = OP_NONE;
    if (accept) begin
      st_n = S_IDLE;
      if (st_q != S_PDATA && ev_data == CMD_ID_EXIT) begin
        id_n = 1'b0;
      end else begin
        unique case (st_q)
          S_IDLE:  if (key_a) st_n = S_KEY1;
          S_KEY1:  if (key_b) st_n = S_KEY2;
          S_KEY2: begin
            if (at_a) begin
              if (ev_data == CMD_PROGRAM)       st_n = S_PDATA;
              else if (ev_data == CMD_SETUP)    st_n = S_SETUP;
              else if (ev_data == CMD_ID_ENTER) id_n = 1'b1;
            end
          end
          S_PDATA: begin
            launch = 1'b1;
            kind_n = OP_PROGRAM;
          end
          S_SETUP: if (key_a) st_n = S_SKEY1;
          S_SKEY1: if (key_b) st_n = S_SKEY2;
          S_SKEY2: begin
            if (at_a && ev_data == CMD_ERASE) begin
              launch = 1'b1;
              kind_n = OP_ERASE;
            end else if (at_a && ev_data == CMD_LOCKOUT) begin
              launch = 1'b1;
              kind_n = OP_LOCKOUT;
            end
          end
          default: st_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      id_q     <= 1'b0;
      op_valid <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      st_q <= st_n;
      id_q <= id_n;
      if (launch) begin
        op_valid <= 1'b1;
        op_kind  <= kind_n;
        op_addr  <= ev_addr;
        op_data  <= ev_data;
      end else if (op_valid && op_ready) begin
        op_valid <= 1'b0;
      end
    end
  end

  assign id_mode = id_q;
endmodule

// File: rtl/ucd_id_mux.sv
`timescale 1ns/1ps
module ucd_id_mux #(
  parameter int                         ADDR_W   = 17,
  parameter logic [ucd_pkg::DATA_W-1:0] MFR_CODE = 8'h1F,
  parameter logic [ucd_pkg::DATA_W-1:0] DEV_CODE = 8'h17
) (
  input  logic                       id_mode,
  input  logic                       lock_state,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [ucd_pkg::DATA_W-1:0] array_rdata,
  output logic [ucd_pkg::DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] ID_MFR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_DEV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_LOCK = ADDR_W'(2);

  always_comb begin
    if (!id_mode) begin
      rd_data = array_rdata;
    end else if (rd_addr == ID_MFR) begin
      rd_data = MFR_CODE;
    end else if (rd_addr == ID_DEV) begin
      rd_data = DEV_CODE;
    end else if (rd_addr == ID_LOCK) begin
      rd_data = {{(ucd_pkg::DATA_W-1){1'b0}}, lock_state};
    end else begin
      rd_data = '0;
    end
  end
endmodule

// File: rtl/unlock_cmd_decoder.sv
`timescale 1ns/1ps
module unlock_cmd_decoder #(
  parameter int          ADDR_W        = 17,
  parameter logic [16:0] UNLOCK_ADDR_A = 17'h05555,
  parameter logic [16:0] UNLOCK_ADDR_B = 17'h02AAA,
  parameter logic [7:0]  MFR_CODE      = 8'h1F,
  parameter logic [7:0]  DEV_CODE      = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              engine_busy,
  input  logic              lock_state,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data
);
  logic              ev_valid;
  logic [ADDR_W-1:0] ev_addr;
  logic [7:0]        ev_data;
  ucd_pkg::op_kind_e kind_w;

  ucd_bus_capture #(.ADDR_W(ADDR_W)) cap_i (
    .clk(clk), .rst_n(rst_n),
    .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
    .addr(bus_addr), .wdata(bus_wdata),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  ucd_seq_fsm #(
    .ADDR_W(ADDR_W), .UNLOCK_ADDR_A(UNLOCK_ADDR_A), .UNLOCK_ADDR_B(UNLOCK_ADDR_B)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .engine_busy(engine_busy),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(kind_w), .op_addr(op_addr), .op_data(op_data),
    .id_mode(id_mode)
  );

  assign op_kind = kind_w;

  ucd_id_mux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) mux_i (
    .id_mode(id_mode), .lock_state(lock_state), .rd_addr(rd_addr),
    .array_rdata(array_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/unlock_cmd_decoder_chk.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_chk #(
  parameter int         ADDR_W   = 17,
  parameter logic [7:0] MFR_CODE = 8'h1F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              engine_busy,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_data,
  input logic              id_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data
);
  assert_op_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_addr) && $stable(op_data));

  assert_op_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> !op_valid);

  assert_no_launch_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> !$past(engine_busy));

  assert_id_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |=> $stable(id_mode));

  assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_kind != 2'd0);

  assert_id_mfr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode && rd_addr == '0 |-> rd_data == MFR_CODE);
endmodule

bind unlock_cmd_decoder unlock_cmd_decoder_chk #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .engine_busy(engine_busy),
  .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
  .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/unlock_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [16:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        engine_busy = 1'b0, lock_state = 1'b0, op_ready = 1'b0;
  logic        op_valid, id_mode;
  logic [1:0]  op_kind;
  logic [16:0] op_addr, rd_addr = '0;
  logic [7:0]  op_data, array_rdata = 8'h5A, rd_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  unlock_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .engine_busy(engine_busy), .lock_state(lock_state),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
    tick();
    bus_addr = a; bus_wdata = d; bus_ce_n = 0; bus_we_n = 0;
    tick();
    tick();
    bus_ce_n = 1; bus_we_n = 1;
    tick();
  endtask

  task automatic unlock_pair();
    bus_write(17'h05555, 8'hAA);
    bus_write(17'h02AAA, 8'h55);
  endtask

  task automatic consume();
    op_ready = 1; tick(); op_ready = 0; tick();
  endtask

  task automatic t_reset();
    check("R1 op_valid", op_valid, 0);
    check("R1 id_mode", id_mode, 0);
    check("R1 rd_data", rd_data, 8'h5A);
  endtask

  task automatic t_program();
    unlock_pair(); bus_write(17'h05555, 8'hA0); bus_write(17'h01234, 8'h3C);
    check("R3 valid", op_valid, 1);
    check("R3 kind", op_kind, 1);
    check("R3 addr", op_addr, 17'h01234);
    check("R3 data", op_data, 8'h3C);
    tick(); tick(); tick();
    check("R11 held valid", op_valid, 1);
    check("R11 held addr", op_addr, 17'h01234);
    consume();
    check("R11 dropped", op_valid, 0);
  endtask

  task automatic t_erase_lock();
    unlock_pair(); bus_write(17'h05555, 8'h80); unlock_pair(); bus_write(17'h05555, 8'h10);
    check("R4 valid", op_valid, 1);
    check("R4 kind", op_kind, 2);
    check("R4 addr", op_addr, 17'h05555);
    check("R4 data", op_data, 8'h10);
    consume();
    unlock_pair(); bus_write(17'h05555, 8'h80); unlock_pair(); bus_write(17'h05555, 8'h40);
    check("R5 valid", op_valid, 1);
    check("R5 kind", op_kind, 3);
    check("R5 data", op_data, 8'h40);
    consume();
  endtask

  task automatic t_id();
    unlock_pair(); bus_write(17'h05555, 8'h90);
    check("R6 id_mode", id_mode, 1);
    check("R6 no op", op_valid, 0);
    lock_state = 1;
    rd_addr = 0; #1 check("R8 mfr", rd_data, 8'h1F);
    rd_addr = 1; #1 check("R8 dev", rd_data, 8'h17);
    rd_addr = 2; #1 check("R8 lock", rd_data, 8'h01);
    lock_state = 0; #1 check("R8 unlock", rd_data, 8'h00);
    rd_addr = 5; #1 check("R8 other", rd_data, 8'h00);
    bus_write(17'h1ABCD, 8'hF0);
    check("R7 single exit", id_mode, 0);
    #1 check("R8 array", rd_data, 8'h5A);
    unlock_pair(); bus_write(17'h05555, 8'h90);
    check("R6 reenter", id_mode, 1);
    unlock_pair(); bus_write(17'h05555, 8'hF0);
    check("R7 three exit", id_mode, 0);
    rd_addr = 0;
  endtask

  task automatic t_mismatch();
    unlock_pair(); bus_write(17'h02AAA, 8'hA0); bus_write(17'h00100, 8'h11);
    check("R9 wrong addr", op_valid, 0);
    unlock_pair(); bus_write(17'h05555, 8'h80); unlock_pair(); bus_write(17'h05555, 8'h30);
    bus_write(17'h05555, 8'h10);
    check("R9 bad final", op_valid, 0);
    bus_write(17'h05555, 8'hAA); bus_write(17'h02AAA, 8'h56);
    bus_write(17'h05555, 8'hA0); bus_write(17'h00200, 8'h22);
    check("R9 bad key", op_valid, 0);
    unlock_pair(); bus_write(17'h05555, 8'hA0); bus_write(17'h00300, 8'h33);
    check("R9 recovers", op_data, 8'h33);
    consume();
  endtask

  task automatic t_busy();
    unlock_pair();
    engine_busy = 1;
    bus_write(17'h05555, 8'h80);
    bus_write(17'h00000, 8'hF0);
    engine_busy = 0;
    bus_write(17'h05555, 8'hA0); bus_write(17'h00400, 8'h44);
    check("R10 resumed kind", op_kind, 1);
    check("R10 resumed data", op_data, 8'h44);
    unlock_pair(); bus_write(17'h05555, 8'hA0); bus_write(17'h00500, 8'h55);
    check("R10 pending addr", op_addr, 17'h00400);
    consume();
    check("R10 no second op", op_valid, 0);
  endtask

  task automatic t_capture();
    unlock_pair(); bus_write(17'h05555, 8'hA0);
    tick(); bus_ce_n = 0; bus_addr = 17'h1FFFF;
    tick(); bus_we_n = 0; bus_addr = 17'h00ABC; bus_wdata = 8'h01;
    tick(); bus_addr = 17'h00DEF; bus_wdata = 8'h02;
    tick(); bus_we_n = 1; bus_wdata = 8'h03;
    tick(); bus_ce_n = 1;
    tick();
    check("R2 addr", op_addr, 17'h00ABC);
    check("R2 data", op_data, 8'h02);
    consume();
    unlock_pair(); bus_write(17'h05555, 8'hA0);
    bus_oe_n = 0; bus_write(17'h00600, 8'h66); bus_oe_n = 1;
    check("R2 inhibited", op_valid, 0);
    bus_write(17'h00700, 8'h77);
    check("R2 step kept", op_data, 8'h77);
    consume();
  endtask

  task automatic t_f0_data();
    unlock_pair(); bus_write(17'h05555, 8'h90);
    unlock_pair(); bus_write(17'h05555, 8'hA0); bus_write(17'h00010, 8'hF0);
    check("R12 data", op_data, 8'hF0);
    check("R12 id kept", id_mode, 1);
    consume();
    bus_write(17'h00000, 8'hF0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 op_valid in reset", op_valid, 0);
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_program();
    t_erase_lock();
    t_id();
    t_mismatch();
    t_busy();
    t_capture();
    t_f0_data();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule